// File: doc/BRIEF.md
# Dual Four-Bit Bidirectional Port Controller

This block gives a small CPU core two 4-bit general-purpose pin groups behind one command strobe. Port A has no direction register. Its whole nibble turns to input whenever the core samples or tests it, and turns to output whenever the core writes it or sets or clears one of its bits. Port B has a direction register, and each pin follows its own bit in that register. Both ports keep an output latch that is separate from the pins. A pin that becomes an output therefore drives the stored latch value.

The core issues one command per cycle. A command carries an operation code, a port select and a 4-bit data field. Commands that sample a port return a data word or a 1-bit test flag in the following cycle. Pin inputs pass through a two-flop synchronizer first. A standby input turns every driver off and makes every sampled value read as zero. Reset is synchronous and active low.

Top module: `gpio_dual_port`

## Requirements
- R1: A port A command (cmd_port=0) with cmd_op READ (0), TEST_HI (1) or TEST_LO (2) leaves all four pin_a_oe bits at 0 after the clock edge that takes it.
- R2: A port A command with cmd_op WRITE (3), SETB (4) or CLRB (5) sets all four pin_a_oe bits to 1 after the edge that takes it. pin_a_out then shows the port A latch.
- R3: Port A never has a mixed direction: pin_a_oe is always 0000 or 1111. A DIR command (6) sent to port A does not change it.
- R4: A DIR command (cmd_op=6) to port B (cmd_port=1) loads cmd_data into the port B direction register. Bit i at 1 makes pin i an output (pin_b_oe[i]=1). No other command changes that register.
- R5: After reset, pin_a_oe, pin_b_oe, pin_a_out, pin_b_out, rd_valid and test_flag are all 0.
- R6: While standby is 1, pin_a_oe and pin_b_oe are 0 in the same cycle. When standby falls, the drivers come back according to the stored direction state.
- R7: A READ or TEST command taken while standby is 1 gives rd_valid=1, rd_data=0 and test_flag=0 in the next cycle.
- R8: SETB and CLRB write 1 or 0 into the latch bit whose index is cmd_data[1:0]. The other three latch bits keep their values.
- R9: WRITE loads cmd_data into the port latch. The latch keeps its value while the port is an input, so a later change to output drives that stored value. Latch writes taken during standby are kept.
- R10: TEST_HI returns test_flag=1 when every pin selected by mask cmd_data is 1. TEST_LO returns test_flag=1 when every selected pin is 0. An empty mask gives 1. READ returns test_flag=0.
- R11: A sampling command sees a pin value only after two clock edges through the synchronizer. A command taken on the first or second edge after a pin change returns the old value, and one taken on the third edge returns the new value.
- R12: A port B READ returns the synchronized pin value for input bits and the latch value for output bits. It does not change port B's directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Drivers off, sampled values read as zero |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation code (0 READ, 1 TEST_HI, 2 TEST_LO, 3 WRITE, 4 SETB, 5 CLRB, 6 DIR, 7 none) |
| cmd_port | input | 1 | 0 selects port A, 1 selects port B |
| cmd_data | input | 4 | Write data, bit index, test mask or direction bits |
| rd_valid | output | 1 | Pulses one cycle after a sampling command |
| rd_data | output | 4 | Sampled port value |
| test_flag | output | 1 | Result of a test command |
| pin_a_in | input | 4 | Port A pin levels |
| pin_a_out | output | 4 | Port A latch value to the drivers |
| pin_a_oe | output | 4 | Port A driver enables |
| pin_b_in | input | 4 | Port B pin levels |
| pin_b_out | output | 4 | Port B latch value to the drivers |
| pin_b_oe | output | 4 | Port B driver enables |

## Verification
Standby can rise in the same cycle that a write reaches port A. In that cycle the latch and the direction state update, but the drivers must stay off. The bench raises standby and sends the write on the same cycle. It then checks that both enables read zero, that port B reads and tests in standby return zeros, and that pin_a_out and pin_a_oe show the written value once standby falls. A pin change can also meet a sampling command in the same cycle. Back-to-back reads starting in that cycle must return the old, old and then new value.

// File: rtl/gpio_pkg.sv
// Package: operation codes and class helpers shared by the port controllers.
// Assumes one 3-bit opcode field on the command strobe.
package gpio_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_TEST_HI = 3'd1,
        OP_TEST_LO = 3'd2,
        OP_WRITE   = 3'd3,
        OP_SETB    = 3'd4,
        OP_CLRB    = 3'd5,
        OP_DIR     = 3'd6,
        OP_NONE    = 3'd7
    } port_op_e;

    // True for commands that sample a port.
    function automatic logic is_in_class(port_op_e op);
        return (op == OP_READ) || (op == OP_TEST_HI) || (op == OP_TEST_LO);
    endfunction

    // True for commands that modify an output latch.
    function automatic logic is_out_class(port_op_e op);
        return (op == OP_WRITE) || (op == OP_SETB) || (op == OP_CLRB);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage input synchronizer for a group of pins.
// Assumes pins are asynchronous to clk; STAGES >= 2.
module gpio_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture raw pins in the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= pin_in;
                end
            end else begin : g_next
                // Purpose: pass the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
// Module: output latch with whole-word write and single-bit set/clear.
// Assumes W is a power of two >= 2; the bit index is the low bits of data.
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  port_op_e     op,
    input  logic [W-1:0] data,
    output logic [W-1:0] latch_q
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] bit_idx;
    assign bit_idx = data[IW-1:0];

    // Purpose: apply write, set-bit and clear-bit commands to the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (hit) begin
            case (op)
                OP_WRITE: latch_q <= data;
                OP_SETB:  latch_q[bit_idx] <= 1'b1;
                OP_CLRB:  latch_q[bit_idx] <= 1'b0;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    // R8: set-bit leaves the other bits alone
    a_r8_setb_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SETB) |=>
            ((latch_q & ~(W'(1) << $past(bit_idx))) == ($past(latch_q) & ~(W'(1) << $past(bit_idx))))
            && latch_q[$past(bit_idx)]);

    // R8: clear-bit leaves the other bits alone
    a_r8_clrb_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_CLRB) |=>
            ((latch_q & ~(W'(1) << $past(bit_idx))) == ($past(latch_q) & ~(W'(1) << $past(bit_idx))))
            && !latch_q[$past(bit_idx)]);

    // R9: sampling commands never touch the latch
    a_r9_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_in_class(op)) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_auto_port.sv
// Module: port whose whole direction follows the class of its last command.
// Assumes hit is already qualified with the port select.
module gpio_auto_port
    import gpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  port_op_e     op,
    input  logic [W-1:0] data,
    output logic [W-1:0] latch_q,
    output logic         dir_out_q
);
    gpio_out_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .op      (op),
        .data    (data),
        .latch_q (latch_q)
    );

    // Purpose: track the one shared direction bit from the command class.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_out_q <= 1'b0;
        else if (hit && is_in_class(op))     dir_out_q <= 1'b0;
        else if (hit && is_out_class(op))    dir_out_q <= 1'b1;
    end

    a_r1_in_class_to_input: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_in_class(op)) |=> !dir_out_q);

    a_r2_out_class_to_output: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_out_class(op)) |=> dir_out_q);

    a_r3_dir_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_DIR) |=> $stable(dir_out_q));
endmodule

// File: rtl/gpio_dir_port.sv
// Module: port with a per-pin direction register loaded by a direction command.
// Assumes hit is already qualified with the port select.
module gpio_dir_port
    import gpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  port_op_e     op,
    input  logic [W-1:0] data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    gpio_out_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .op      (op),
        .data    (data),
        .latch_q (latch_q)
    );

    // Purpose: load per-pin directions, 1 meaning output.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dir_q <= '0;
        else if (hit && op == OP_DIR)   dir_q <= data;
    end

    a_r4_dir_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_DIR) |=> (dir_q == $past(data)));

    a_r12_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && op == OP_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_resp.sv
// Module: registers the response of sampling commands (data and test flag).
// Assumes the port views are already synchronized; standby zeroes the view.
module gpio_resp
    import gpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         valid,
    input  port_op_e     op,
    input  logic         port_sel,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] view_a,
    input  logic [W-1:0] view_b,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         test_flag
);
    logic [W-1:0] view;
    logic         all_hi;
    logic         all_lo;
    logic         flag_next;

    // Purpose: pick the addressed port and blank it in standby.
    always_comb begin
        view      = standby ? '0 : (port_sel ? view_b : view_a);
        all_hi    = &(~mask | view);
        all_lo    = &(~mask | ~view);
        case (op)
            OP_TEST_HI: flag_next = all_hi && !standby;
            OP_TEST_LO: flag_next = all_lo && !standby;
            default:    flag_next = 1'b0;
        endcase
    end

    // Purpose: register the response of a sampling command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            test_flag <= 1'b0;
        end else begin
            rd_valid <= valid && is_in_class(op);
            if (valid && is_in_class(op)) begin
                rd_data   <= view;
                test_flag <= flag_next;
            end
        end
    end

    a_r7_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && standby && is_in_class(op)) |=> (rd_valid && rd_data == '0 && !test_flag));

    a_r10_read_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_READ) |=> !test_flag);
endmodule

// File: rtl/gpio_dual_port.sv
// Module: top of the two-port controller; decodes the command strobe,
// gates drivers with standby and forms the sampled views.
// Assumes one command per cycle and asynchronous pin inputs.
module gpio_dual_port
    import gpio_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic         cmd_port,
    input  logic [W-1:0] cmd_data,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         test_flag,
    input  logic [W-1:0] pin_a_in,
    output logic [W-1:0] pin_a_out,
    output logic [W-1:0] pin_a_oe,
    input  logic [W-1:0] pin_b_in,
    output logic [W-1:0] pin_b_out,
    output logic [W-1:0] pin_b_oe
);
    port_op_e     op;
    logic         hit_a, hit_b;
    logic [W-1:0] sync_a, sync_b;
    logic [W-1:0] latch_a, latch_b;
    logic         dir_a;
    logic [W-1:0] dir_b;
    logic [W-1:0] view_b;

    assign op    = port_op_e'(cmd_op);
    assign hit_a = cmd_valid && !cmd_port;
    assign hit_b = cmd_valid &&  cmd_port;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_a_in), .pin_sync(sync_a));

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_b_in), .pin_sync(sync_b));

    gpio_auto_port #(.W(W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .hit(hit_a), .op(op), .data(cmd_data),
        .latch_q(latch_a), .dir_out_q(dir_a));

    gpio_dir_port #(.W(W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .hit(hit_b), .op(op), .data(cmd_data),
        .latch_q(latch_b), .dir_q(dir_b));

    // Purpose: port B view mixes latch for outputs and pins for inputs.
    always_comb begin
        view_b = (dir_b & latch_b) | (~dir_b & sync_b);
    end

    gpio_resp #(.W(W)) u_resp (
        .clk(clk), .rst_n(rst_n), .standby(standby), .valid(cmd_valid),
        .op(op), .port_sel(cmd_port), .mask(cmd_data),
        .view_a(sync_a), .view_b(view_b),
        .rd_valid(rd_valid), .rd_data(rd_data), .test_flag(test_flag));

    // Purpose: drive latches and gate enables with standby.
    always_comb begin
        pin_a_out = latch_a;
        pin_b_out = latch_b;
        pin_a_oe  = standby ? '0 : {W{dir_a}};
        pin_b_oe  = standby ? '0 : dir_b;
    end

    a_r6_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (pin_a_oe == '0 && pin_b_oe == '0));

    a_r3_uniform_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_a_oe == '0) || (pin_a_oe == '1));
endmodule

// File: tb/sim_gpio_dual_port.sv
// Directed bench for gpio_dual_port; one task per scenario.
module sim_gpio_dual_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd7;
    logic       cmd_port = 1'b0;
    logic [3:0] cmd_data = 4'h0;
    logic       rd_valid, test_flag;
    logic [3:0] rd_data;
    logic [3:0] pin_a_in = 4'h0, pin_b_in = 4'h0;
    logic [3:0] pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [2:0] RD = 3'd0, THI = 3'd1, TLO = 3'd2, WR = 3'd3,
                           SB = 3'd4, CB = 3'd5, DR = 3'd6;

    always #2 clk = ~clk;

    gpio_dual_port u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .test_flag(test_flag),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe));

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Issue one command at a negedge; return at the following negedge.
    task automatic issue(input logic p, input logic [2:0] op, input logic [3:0] d);
        cmd_valid = 1'b1; cmd_port = p; cmd_op = op; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 3'd7;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R5 a_oe", pin_a_oe, 0);
        check("R5 b_oe", pin_b_oe, 0);
        check("R5 a_out", pin_a_out, 0);
        check("R5 b_out", pin_b_out, 0);
        check("R5 rd_valid", rd_valid, 0);
        check("R5 test_flag", test_flag, 0);
    endtask

    task automatic t_auto_dir();
        pin_a_in = 4'h5; idle(3);
        issue(0, WR, 4'hA);
        check("R2 write oe", pin_a_oe, 4'hF);
        check("R9 write out", pin_a_out, 4'hA);
        issue(0, RD, 4'h0);
        check("R1 read oe", pin_a_oe, 4'h0);
        check("R1 read valid", rd_valid, 1);
        check("R1 read data", rd_data, 4'h5);
        check("R9 latch kept while input", pin_a_out, 4'hA);
        issue(0, SB, 4'h0);
        check("R8 setb out", pin_a_out, 4'hB);
        check("R2 setb oe", pin_a_oe, 4'hF);
        issue(0, CB, 4'h3);
        check("R8 clrb out", pin_a_out, 4'h3);
        issue(0, THI, 4'h1);
        check("R1 test oe", pin_a_oe, 4'h0);
        issue(0, DR, 4'hF);
        check("R3 dir ignored on A", pin_a_oe, 4'h0);
        issue(0, CB, 4'h0);
        check("R2 clrb oe", pin_a_oe, 4'hF);
        check("R9 stored latch driven", pin_a_out, 4'h2);
        issue(0, TLO, 4'h0);
        check("R1 testlo oe", pin_a_oe, 4'h0);
    endtask

    task automatic t_tests();
        pin_a_in = 4'b1010; idle(3);
        issue(0, THI, 4'b1010); check("R10 hi all set", test_flag, 1);
        issue(0, THI, 4'b1011); check("R10 hi one low", test_flag, 0);
        issue(0, TLO, 4'b0101); check("R10 lo all clear", test_flag, 1);
        issue(0, TLO, 4'b1000); check("R10 lo one high", test_flag, 0);
        issue(0, THI, 4'b0000); check("R10 empty mask", test_flag, 1);
        issue(0, RD,  4'b0000); check("R10 read flag", test_flag, 0);
    endtask

    task automatic t_port_b();
        issue(1, DR, 4'b0011);
        check("R4 dir b", pin_b_oe, 4'b0011);
        issue(1, WR, 4'h9);
        check("R9 b out", pin_b_out, 4'h9);
        check("R4 write keeps dir", pin_b_oe, 4'b0011);
        pin_b_in = 4'b0110; idle(3);
        issue(1, RD, 4'h0);
        check("R12 mixed read", rd_data, 4'b0101);
        check("R12 read keeps dir", pin_b_oe, 4'b0011);
        issue(1, SB, 4'h2);
        check("R8 b setb", pin_b_out, 4'hD);
    endtask

    task automatic t_sync();
        pin_a_in = 4'h3; idle(4);
        pin_a_in = 4'hC;
        issue(0, RD, 4'h0); check("R11 edge1 old", rd_data, 4'h3);
        issue(0, RD, 4'h0); check("R11 edge2 old", rd_data, 4'h3);
        issue(0, RD, 4'h0); check("R11 edge3 new", rd_data, 4'hC);
    endtask

    task automatic t_standby();
        issue(0, WR, 4'h5);
        issue(1, DR, 4'hF);
        pin_b_in = 4'hF;
        standby = 1'b1;
        issue(0, WR, 4'hE);
        check("R6 a hiz", pin_a_oe, 0);
        check("R6 b hiz", pin_b_oe, 0);
        issue(1, RD, 4'h0);
        check("R7 read valid", rd_valid, 1);
        check("R7 read zero", rd_data, 0);
        issue(1, TLO, 4'hF);
        check("R7 test zero", test_flag, 0);
        standby = 1'b0; #1;
        check("R6 a back", pin_a_oe, 4'hF);
        check("R9 standby write kept", pin_a_out, 4'hE);
        check("R6 b back", pin_b_oe, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_auto_dir();
        t_tests();
        t_port_b();
        t_sync();
        t_standby();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule